// File: doc/BRIEF.md
# Eight-Operation Combinational ALU

This block is a purely combinational arithmetic logic unit. It takes two unsigned operands, a left-hand value and a right-hand value, and a 3-bit operation code. It returns a result twice the operand width, so the full product always fits. Every operation has the form `lhs OP rhs`. The set covers sum, difference, product, integer quotient, remainder, and bitwise AND, OR and XOR.

Two comparison flags are computed on every input, whatever the operation code. One reports that the operands are equal. The other reports that the left-hand operand is strictly larger, with both operands treated as unsigned. The block has no clock, no reset and no storage, so its outputs depend only on its present inputs.

A zero right-hand operand gives a defined quotient and remainder. The outputs therefore never become unknown.

Top module: `octal_op_alu`

## Requirements
- R1: Op code 3'b000 returns lhs + rhs, zero-extended to the result width; a carry appears in bit W (bit 8 at the default width).
- R2: Op code 3'b001 returns lhs - rhs modulo 2^(2W); when rhs > lhs the result is the two's-complement wraparound (for example 16'hFFFF for 0 - 1).
- R3: Op code 3'b010 returns the full unsigned product lhs * rhs.
- R4: Op code 3'b011 returns the unsigned integer quotient lhs / rhs, zero-extended; when rhs is zero it returns all ones (16'hFFFF).
- R5: Op code 3'b100 returns lhs % rhs, zero-extended; when rhs is zero it returns lhs, zero-extended.
- R6: Op codes 3'b101, 3'b110 and 3'b111 return lhs AND rhs, lhs OR rhs and lhs XOR rhs respectively, zero-extended.
- R7: equal_o is 1 exactly when lhs equals rhs, for every op code.
- R8: greater_o is 1 exactly when lhs is greater than rhs as unsigned values, for every op code; it is never 1 together with equal_o.
- R9: The block holds no state: the same inputs give the same outputs whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs_i | input | W (8) | Left-hand unsigned operand |
| rhs_i | input | W (8) | Right-hand unsigned operand |
| op_i | input | 3 | Operation code |
| result_o | output | 2W (16) | Operation result |
| equal_o | output | 1 | lhs equals rhs |
| greater_o | output | 1 | lhs greater than rhs, unsigned |

## Verification
The bench builds the ALU at its default operand width of 8, which gives a 16-bit result. At that width directed pairs can reach every boundary: the carry into bit 8, the wraparound of a negative difference, the largest product 255*255, and a zero divisor for both quotient and remainder. Every op code is applied to each directed pair and to a few hundred random pairs, and the result and both flags are compared with a behavioural model. Afterwards a pair seen earlier is applied again to show that earlier inputs leave no trace.

// File: rtl/octal_alu_pkg.sv
`timescale 1ns/1ps
package octal_alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MUL = 3'b010,
    OP_DIV = 3'b011,
    OP_REM = 3'b100,
    OP_AND = 3'b101,
    OP_OR  = 3'b110,
    OP_XOR = 3'b111
  } alu_op_e;
endpackage

// File: rtl/octal_alu_arith.sv
`timescale 1ns/1ps
// Sum, difference and product, all widened to the result width first.
module octal_alu_arith #(
  parameter int W  = 8,
  parameter int RW = 2 * W
) (
  input  logic [W-1:0]  lhs_i,
  input  logic [W-1:0]  rhs_i,
  output logic [RW-1:0] sum_o,
  output logic [RW-1:0] diff_o,
  output logic [RW-1:0] prod_o
);
  logic [RW-1:0] lhs_x;
  logic [RW-1:0] rhs_x;

  assign lhs_x  = RW'(lhs_i);
  assign rhs_x  = RW'(rhs_i);
  assign sum_o  = lhs_x + rhs_x;
  assign diff_o = lhs_x - rhs_x;
  assign prod_o = lhs_x * rhs_x;
endmodule

// File: rtl/octal_alu_divider.sv
`timescale 1ns/1ps
// Unsigned quotient and remainder; a zero divisor yields all-ones / lhs.
module octal_alu_divider #(
  parameter int W  = 8,
  parameter int RW = 2 * W
) (
  input  logic [W-1:0]  lhs_i,
  input  logic [W-1:0]  rhs_i,
  output logic [RW-1:0] quot_o,
  output logic [W-1:0]  rem_o
);
  logic rhs_zero;
  assign rhs_zero = (rhs_i == '0);

  always_comb begin
    if (rhs_zero) begin
      quot_o = '1;
      rem_o  = lhs_i;
    end else begin
      quot_o = RW'(lhs_i / rhs_i);
      rem_o  = lhs_i % rhs_i;
    end
  end
endmodule

// File: rtl/octal_alu_bitwise.sv
`timescale 1ns/1ps
// Per-bit lanes for AND, OR, XOR.
module octal_alu_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o
);
  for (genvar b = 0; b < W; b++) begin : g_lane
    assign and_o[b] = lhs_i[b] & rhs_i[b];
    assign or_o[b]  = lhs_i[b] | rhs_i[b];
    assign xor_o[b] = lhs_i[b] ^ rhs_i[b];
  end
endmodule

// File: rtl/octal_alu_compare.sv
`timescale 1ns/1ps
// Unsigned magnitude comparison, independent of the op code.
module octal_alu_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic         eq_o,
  output logic         gt_o
);
  assign eq_o = (lhs_i == rhs_i);
  assign gt_o = (lhs_i > rhs_i);
endmodule

// File: rtl/octal_op_alu.sv
`timescale 1ns/1ps
module octal_op_alu #(
  parameter int W = 8,
  localparam int RW = 2 * W
) (
  input  logic [W-1:0]                     lhs_i,
  input  logic [W-1:0]                     rhs_i,
  input  logic [octal_alu_pkg::OP_W-1:0]   op_i,
  output logic [RW-1:0]                    result_o,
  output logic                             equal_o,
  output logic                             greater_o
);
  import octal_alu_pkg::*;

  logic [RW-1:0] sum, diff, prod, quot;
  logic [W-1:0]  rem, band, bor, bxor;
  logic          eq, gt;
  alu_op_e       op;

  assign op = alu_op_e'(op_i);

  octal_alu_arith #(.W(W), .RW(RW)) u_arith (
    .lhs_i(lhs_i), .rhs_i(rhs_i),
    .sum_o(sum), .diff_o(diff), .prod_o(prod)
  );

  octal_alu_divider #(.W(W), .RW(RW)) u_div (
    .lhs_i(lhs_i), .rhs_i(rhs_i),
    .quot_o(quot), .rem_o(rem)
  );

  octal_alu_bitwise #(.W(W)) u_bits (
    .lhs_i(lhs_i), .rhs_i(rhs_i),
    .and_o(band), .or_o(bor), .xor_o(bxor)
  );

  octal_alu_compare #(.W(W)) u_cmp (
    .lhs_i(lhs_i), .rhs_i(rhs_i),
    .eq_o(eq), .gt_o(gt)
  );

  always_comb begin
    case (op)
      OP_ADD:  result_o = sum;
      OP_SUB:  result_o = diff;
      OP_MUL:  result_o = prod;
      OP_DIV:  result_o = quot;
      OP_REM:  result_o = RW'(rem);
      OP_AND:  result_o = RW'(band);
      OP_OR:   result_o = RW'(bor);
      OP_XOR:  result_o = RW'(bxor);
      default: result_o = '0;
    endcase
  end

  assign equal_o   = eq;
  assign greater_o = gt;

  // Cross-checks between the independent units.
  always_comb begin
    assert_flags_exclusive_R8: assert (!(eq && gt))
      else $error("equal and greater both set");
    if (eq) begin
      assert_eq_zero_diff_R7: assert (diff == '0)
        else $error("equal operands with nonzero difference");
    end
    if (gt) begin
      assert_gt_diff_small_R2: assert (diff[RW-1:W] == '0 && diff != '0)
        else $error("greater operands gave an out-of-range difference");
    end
    if (!gt && !eq) begin
      assert_lt_diff_wrap_R2: assert (diff[RW-1:W] == '1)
        else $error("smaller lhs did not wrap the difference");
    end
    if (rhs_i != '0) begin
      assert_rem_below_div_R5: assert (rem < rhs_i)
        else $error("remainder not below divisor");
      assert_div_identity_R4: assert (RW'(quot[W-1:0]) * RW'(rhs_i) + RW'(rem) == RW'(lhs_i))
        else $error("quotient and remainder do not rebuild lhs");
    end
  end
endmodule

// File: tb/octal_op_alu_tb_top.sv
`timescale 1ns/1ps
module octal_op_alu_tb_top;
  localparam int W  = 8;
  localparam int RW = 16;

  logic clk;
  logic rst_n;
  logic [W-1:0]  lhs, rhs;
  logic [2:0]    op;
  logic [RW-1:0] result;
  logic          equal, greater;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  string res_tag [8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R6", "R6"};

  octal_op_alu #(.W(W)) dut_i (
    .lhs_i(lhs), .rhs_i(rhs), .op_i(op),
    .result_o(result), .equal_o(equal), .greater_o(greater)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [RW-1:0] model(input int o, input int l, input int r);
    int v;
    case (o)
      0: v = l + r;
      1: v = (l - r) & 32'h0000FFFF;
      2: v = l * r;
      3: v = (r == 0) ? 32'h0000FFFF : l / r;
      4: v = (r == 0) ? l : l % r;
      5: v = l & r;
      6: v = l | r;
      default: v = l ^ r;
    endcase
    return v[RW-1:0];
  endfunction

  task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (lhs=%0d rhs=%0d op=%0d)", tag, act, exp, lhs, rhs, op);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Drive after a rising edge, compare at the following falling edge.
  task automatic apply(input int l, input int r, input int o);
    @(posedge clk);
    lhs = l[W-1:0];
    rhs = r[W-1:0];
    op  = o[2:0];
    @(negedge clk);
    chk(res_tag[o], result, model(o, l, r));
    chk("R7", {15'b0, equal}, {15'b0, (l == r)});
    chk("R8", {15'b0, greater}, {15'b0, (l > r)});
  endtask

  task automatic all_ops(input int l, input int r);
    for (int o = 0; o < 8; o++) apply(l, r, o);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [RW-1:0] first;
    lhs = '0; rhs = '0; op = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state with zero inputs: sum of zeros, flags equal.
    chk("R1", result, 16'h0000);
    chk("R7", {15'b0, equal}, 16'h0001);
    chk("R8", {15'b0, greater}, 16'h0000);
    rst_n = 1'b1;

    // Directed pairs (lhs, rhs).
    all_ops(0, 0);
    all_ops(10, 100);
    all_ops(100, 10);
    all_ops(42, 42);
    all_ops(42, 7);
    all_ops(255, 255);
    all_ops(255, 0);
    all_ops(0, 255);
    all_ops(1, 0);
    all_ops(128, 128);

    // Named boundaries.
    apply(255, 1, 0);  chk("R1", result, 16'h0100);
    apply(0, 1, 1);    chk("R2", result, 16'hFFFF);
    apply(255, 255, 2); chk("R3", result, 16'hFE01);
    apply(77, 0, 3);   chk("R4", result, 16'hFFFF);
    apply(77, 0, 4);   chk("R5", result, 16'h004D);

    // Random pairs.
    for (int i = 0; i < 300; i++) begin
      int l, r;
      l = int'($urandom_range(0, 255));
      r = int'($urandom_range(0, 255));
      all_ops(l, r);
    end

    // R9: revisit a pair after unrelated traffic; outputs must repeat.
    apply(42, 7, 4);
    first = result;
    apply(200, 3, 2);
    apply(0, 0, 7);
    apply(42, 7, 4);
    chk("R9", result, first);

    finish_run();
  end
endmodule